// File: doc/BRIEF.md
# Block-Bypass Decimal Adder

This block adds two packed decimal numbers of `NUM_DIGITS` digits, each digit a 4-bit code from 0 to 9, plus an incoming carry. It gives back the decimal sum digits and a carry out of the top digit. The block is purely combinational.

Each digit stage does a binary add and then a correction. When the binary result goes past 9, or when the binary add carries out, the stage adds 6 and raises its decimal carry.

The digits are grouped into blocks of `BLOCK_DIGITS` stages. Inside a block the carry ripples from stage to stage. Alongside the ripple, each block has a bypass path. When every digit pair in the block sums to exactly 9, the block carry-in is forwarded straight to the block carry-out.

The bypass is a timing aid only. The results always equal those of a plain rippled decimal adder. The parameter `SKIP_EN` selects the bypass variant or the plain ripple variant.

Top module: `bcd_skip_adder`

## Requirements
- R1: Each sum digit i equals (a digit i + b digit i + carry into digit i) mod 10. The carry into digit 0 is `carry_i`. Digit i occupies bits [4i+3:4i] of each bus.
- R2: `carry_o` is 1 exactly when the decimal value of `a_i` plus the decimal value of `b_i` plus `carry_i` is at least 10^NUM_DIGITS.
- R3: A digit pair summing to exactly 9 passes its carry through. With carry-in 0 it gives digit 9 and carry-out 0. With carry-in 1 it gives digit 0 and carry-out 1.
- R4: When every digit pair sums to exactly 9, `carry_o` equals `carry_i`. Every sum digit is then 9 if `carry_i` is 0, and 0 if `carry_i` is 1.
- R5: A digit stage maps every total from 0 to 19 correctly, including these cases:
  - 10 gives digit 0 with carry 1;
  - 16, where the binary add itself carries, gives digit 6 with carry 1;
  - 19 gives digit 9 with carry 1.
- R6: For valid input digits, every sum digit lies in 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*NUM_DIGITS | First operand, packed decimal, least significant digit in bits [3:0] |
| b_i | input | 4*NUM_DIGITS | Second operand, same layout |
| carry_i | input | 1 | Carry into the least significant digit |
| sum_o | output | 4*NUM_DIGITS | Packed decimal sum digits |
| carry_o | output | 1 | Carry out of the most significant digit |

## Verification
Directed vectors cover three groups of digit-stage totals:
- totals of 10, 16 and 19, which separate the "greater than 9" trigger from the "binary carry" trigger for the add-6 correction;
- operands whose pairs all sum to 9, under both carry-in values, which exercise the bypass in every block;
- mixed operands, where only some pairs sum to 9, so that a wrongly taken bypass would corrupt the carry.

Random valid operands are compared against a reference that converts the operands to integers, adds them and converts the result back. This exposes any misrouted carry between blocks.

// File: rtl/bcd_skip_pkg.sv
package bcd_skip_pkg;
   localparam int DIGIT_W = 4;
   localparam int RADIX   = 10;
   typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
   import bcd_skip_pkg::*;
(
   input  digit_t a_d,
   input  digit_t b_d,
   input  logic   cin,
   output digit_t sum_d,
   output logic   cout,
   output logic   pass_d
);
   logic [DIGIT_W:0] raw;
   logic             fix;

   always_comb begin
      raw    = {1'b0, a_d} + {1'b0, b_d} + {{DIGIT_W{1'b0}}, cin};
      fix    = raw[DIGIT_W] | (raw[3] & (raw[2] | raw[1]));
      sum_d  = fix ? (raw[DIGIT_W-1:0] + digit_t'(RADIX - 4)) : raw[DIGIT_W-1:0];
      cout   = fix;
      pass_d = (({1'b0, a_d} + {1'b0, b_d}) == (DIGIT_W+1)'(RADIX - 1));
   end
endmodule

// File: rtl/bcd_skip_block.sv
module bcd_skip_block
   import bcd_skip_pkg::*;
#(
   parameter int BLOCK_DIGITS = 2,
   parameter bit SKIP_EN      = 1'b1,
   localparam int BW          = BLOCK_DIGITS * DIGIT_W
) (
   input  logic [BW-1:0] a_b,
   input  logic [BW-1:0] b_b,
   input  logic          cin,
   output logic [BW-1:0] sum_b,
   output logic          cout
);
   logic [BLOCK_DIGITS:0]   rc;
   logic [BLOCK_DIGITS-1:0] pass;

   assign rc[0] = cin;

   for (genvar d = 0; d < BLOCK_DIGITS; d++) begin : g_stage
      bcd_digit_stage i_stage (
         .a_d   (a_b[d*DIGIT_W +: DIGIT_W]),
         .b_d   (b_b[d*DIGIT_W +: DIGIT_W]),
         .cin   (rc[d]),
         .sum_d (sum_b[d*DIGIT_W +: DIGIT_W]),
         .cout  (rc[d+1]),
         .pass_d(pass[d])
      );
   end

   if (SKIP_EN) begin : g_bypass
      assign cout = rc[BLOCK_DIGITS] | ((&pass) & cin);
   end else begin : g_ripple
      logic unused_pass;
      assign unused_pass = ^pass;
      assign cout = rc[BLOCK_DIGITS];
   end
endmodule

// File: rtl/bcd_skip_adder.sv
module bcd_skip_adder
   import bcd_skip_pkg::*;
#(
   parameter int NUM_DIGITS   = 8,
   parameter int BLOCK_DIGITS = 2,
   parameter bit SKIP_EN      = 1'b1,
   localparam int W           = NUM_DIGITS * DIGIT_W,
   localparam int NUM_BLOCKS  = NUM_DIGITS / BLOCK_DIGITS,
   localparam int BW          = BLOCK_DIGITS * DIGIT_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         carry_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o
);
   if (BLOCK_DIGITS < 1 || NUM_DIGITS < 1) begin : g_bad_size
      $error("bcd_skip_adder: digit counts must be positive");
   end
   if (NUM_DIGITS % BLOCK_DIGITS != 0) begin : g_bad_split
      $error("bcd_skip_adder: NUM_DIGITS must be a multiple of BLOCK_DIGITS");
   end

   logic [NUM_BLOCKS:0] bc;
   assign bc[0] = carry_i;

   for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_blk
      bcd_skip_block #(
         .BLOCK_DIGITS(BLOCK_DIGITS),
         .SKIP_EN     (SKIP_EN)
      ) i_blk (
         .a_b  (a_i[k*BW +: BW]),
         .b_b  (b_i[k*BW +: BW]),
         .cin  (bc[k]),
         .sum_b(sum_o[k*BW +: BW]),
         .cout (bc[k+1])
      );
   end

   assign carry_o = bc[NUM_BLOCKS];
endmodule

// File: rtl/bcd_skip_adder_chk.sv
module bcd_skip_adder_chk #(
   parameter int NUM_DIGITS = 8,
   localparam int W         = NUM_DIGITS * 4
) (
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic         carry_i,
   input logic [W-1:0] sum_o,
   input logic         carry_o
);
   logic valid_in, all_nine, ok_digits, ok_range, ref_c;

   always_comb begin
      logic c;
      logic [4:0] t;
      valid_in  = 1'b1;
      all_nine  = 1'b1;
      ok_digits = 1'b1;
      ok_range  = 1'b1;
      c = carry_i;
      for (int i = 0; i < NUM_DIGITS; i++) begin
         if (a_i[i*4 +: 4] > 4'd9 || b_i[i*4 +: 4] > 4'd9) valid_in = 1'b0;
         t = {1'b0, a_i[i*4 +: 4]} + {1'b0, b_i[i*4 +: 4]};
         if (t != 5'd9) all_nine = 1'b0;
         t = t + {4'd0, c};
         if (t >= 5'd10) begin
            if (sum_o[i*4 +: 4] != 4'(t - 5'd10)) ok_digits = 1'b0;
            c = 1'b1;
         end else begin
            if (sum_o[i*4 +: 4] != t[3:0]) ok_digits = 1'b0;
            c = 1'b0;
         end
         if (sum_o[i*4 +: 4] > 4'd9) ok_range = 1'b0;
      end
      ref_c = c;
   end

   always_comb begin
      // R1
      digit_value_chk: assert (!valid_in || ok_digits);
      // R2
      carry_out_chk: assert (!valid_in || carry_o == ref_c);
      // R4
      bypass_all_chk: assert (!(valid_in && all_nine) || carry_o == carry_i);
      // R6
      digit_range_chk: assert (!valid_in || ok_range);
      // R3
      low_pass_chk: assert (!(valid_in && ({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]}) == 5'd9)
                            || sum_o[3:0] == (carry_i ? 4'd0 : 4'd9));
   end
endmodule

bind bcd_skip_adder bcd_skip_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .carry_i(carry_i),
   .sum_o  (sum_o),
   .carry_o(carry_o)
);

// File: tb/test_bcd_skip_adder.sv
module test_bcd_skip_adder;
   localparam int N = 8;
   localparam int W = N * 4;
   localparam int NV = 15;
   localparam int VW = 3 * W + 2 + 8;

   // fields: tag[7:0], a, b, cin, exp_sum, exp_carry
   localparam logic [VW-1:0] VEC [NV] = '{
      {8'd6, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0}, // R6 zero
      {8'd4, 32'h99999999, 32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R4
      {8'd4, 32'h45454545, 32'h54545454, 1'b0, 32'h99999999, 1'b0}, // R4
      {8'd4, 32'h45454545, 32'h54545454, 1'b1, 32'h00000000, 1'b1}, // R4
      {8'd5, 32'h00000009, 32'h00000009, 1'b1, 32'h00000019, 1'b0}, // R5 total 19
      {8'd5, 32'h00000008, 32'h00000008, 1'b0, 32'h00000016, 1'b0}, // R5 binary carry
      {8'd5, 32'h00000007, 32'h00000003, 1'b0, 32'h00000010, 1'b0}, // R5 total 10
      {8'd1, 32'h12345678, 32'h87654321, 1'b0, 32'h99999999, 1'b0}, // R1
      {8'd2, 32'h12345678, 32'h87654322, 1'b0, 32'h00000000, 1'b1}, // R2
      {8'd2, 32'h50000000, 32'h50000000, 1'b0, 32'h00000000, 1'b1}, // R2
      {8'd3, 32'h00000036, 32'h00000063, 1'b1, 32'h00000100, 1'b0}, // R3
      {8'd3, 32'h00000036, 32'h00000063, 1'b0, 32'h00000099, 1'b0}, // R3
      {8'd1, 32'h00001234, 32'h00005678, 1'b0, 32'h00006912, 1'b0}, // R1
      {8'd5, 32'h99999999, 32'h99999999, 1'b1, 32'h99999999, 1'b1}, // R5 max
      {8'd1, 32'h00000054, 32'h00000046, 1'b0, 32'h00000100, 1'b0}  // R1 partial pass
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] a, b, s;
   logic cin, cout;
   int total = 0, bad = 0;
   bit done = 1'b0;

   bcd_skip_adder #(.NUM_DIGITS(N), .BLOCK_DIGITS(2)) i_bcd_skip_adder (
      .a_i(a), .b_i(b), .carry_i(cin), .sum_o(s), .carry_o(cout)
   );

   function automatic longint to_int(input logic [W-1:0] v);
      longint r = 0;
      for (int i = N - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
      return r;
   endfunction

   function automatic logic [W-1:0] to_bcd(input longint v);
      logic [W-1:0] r;
      for (int i = 0; i < N; i++) begin
         r[i*4 +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic check(input int tag, input logic [W-1:0] es, input logic ec);
      total++;
      if (s !== es || cout !== ec) begin
         bad++;
         $display("FAIL R%0d: a=%h b=%h cin=%b got sum=%h carry=%b exp sum=%h carry=%b",
                  tag, a, b, cin, s, cout, es, ec);
      end
   endtask

   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      @(posedge clk);
      a = av; b = bv; cin = cv;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; cin = 1'b0;
      @(negedge clk);
      check(6, '0, 1'b0); // R6 initial zero state

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][VW-9 -: W], VEC[v][VW-9-W -: W], VEC[v][W+1]);
         check(int'(VEC[v][VW-1 -: 8]), VEC[v][W:1], VEC[v][0]);
      end

      // R1 R2 R6: random valid operands against integer reference
      for (int r = 0; r < 300; r++) begin
         logic [W-1:0] ra, rb;
         logic rc;
         longint tot, lim;
         bit rng;
         for (int d = 0; d < N; d++) begin
            ra[d*4 +: 4] = 4'($urandom % 10);
            rb[d*4 +: 4] = 4'($urandom % 10);
         end
         rc = 1'($urandom);
         apply(ra, rb, rc);
         lim = 100000000;
         tot = to_int(ra) + to_int(rb) + longint'(rc);
         check(2, to_bcd(tot % lim), tot >= lim);
         rng = 1'b1;
         for (int d = 0; d < N; d++) if (s[d*4 +: 4] > 4'd9) rng = 1'b0;
         total++;
         if (!rng) begin
            bad++;
            $display("FAIL R6: got sum=%h exp all digits <= 9", s);
         end
      end

      // R4: all-pass blocks with mixed pair splits, both carry-in values
      for (int k = 0; k < 10; k++) begin
         logic [W-1:0] pa, pb;
         for (int d = 0; d < N; d++) begin
            pa[d*4 +: 4] = 4'((k + d) % 10);
            pb[d*4 +: 4] = 4'(9 - ((k + d) % 10));
         end
         apply(pa, pb, 1'b0);
         check(4, {N{4'h9}}, 1'b0);
         apply(pa, pb, 1'b1);
         check(4, '0, 1'b1);
      end

      // R5: every single-digit total 0..19
      for (int t = 0; t < 20; t++) begin
         int x, y, c;
         c = (t > 18) ? 1 : 0;
         x = (t - c > 9) ? 9 : t - c;
         y = t - c - x;
         apply(W'(x), W'(y), 1'(c));
         check(5, W'(((t / 10) << 4) | (t % 10)), 1'b0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule